// File: doc/BRIEF.md
# Processor Stop-Clock Power State Controller

This block follows a processor core through its low-power states. It watches the bus-side stop-clock and sleep request pins, which are active low. It also watches the halt indication, the snoop request and snoop-done strobes, the wake events, and the strobe that marks the response phase of the stop-grant acknowledge cycle. From these it keeps a registered state. The states are normal operation, halted, halted while snooping, stop granted, stop granted while snooping, and sleep. It decodes the state into the enables that the rest of the core uses to accept snoops and interrupts.

Entry into stop grant is deliberately slow. The acknowledge strobe starts a fixed delay, and the state changes only when that delay has run out. A bus-init event that arrives while the clock is stopped is not serviced at that time. It is held and reported as a single pulse when the machine leaves the stopped states. A reset event reinitialises the core without disturbing the stopped state. The block also raises a sticky error when the system controller releases the stop-clock request in an illegal order.

Top module: `pwr_stpclk_ctrl`

## Requirements
- R1: State codes on `state_o` are: 0 normal, 1 halt, 2 halt-snoop, 3 grant, 4 grant-snoop, 5 sleep. The acknowledge strobe must be sampled high while `stop_req_ni` is low and the state is 0, 1 or 2. When that happens, the state becomes 3 (or 4 from 2) exactly GRANT_DELAY (default 20) clock edges after the sampling edge, and not earlier.
- R2: If `stop_req_ni` goes high while the state is not 3 or 4, `seq_err_o` is set and stays set until reset. A grant delay already in progress is cancelled, so no later grant happens without a new acknowledge strobe.
- R3: With the state at 3, after an entry from normal, a high `stop_req_ni` returns the state to 0 on the next edge. This release is legal.
- R4: In state 3, `sleep_req_ni` low moves the state to 5, and `sleep_req_ni` high in state 5 moves it back to 3. In every other state the sleep request has no effect.
- R5: In state 5, both `snoop_en_o` and `intr_en_o` are low. `grant_o` is high in states 3, 4 and 5 and low otherwise.
- R6: A rise of `stop_req_ni` while in state 5 sets `seq_err_o`. This includes a rise sampled on the same edge as the release of `sleep_req_ni`. A rise one or more edges after the release, with the state already at 3, does not set it.
- R7: A bus-init event sampled in states 3, 4 or 5 is held internally, and `binit_pend_o` stays low meanwhile. On the edge where the state leaves that group, `binit_pend_o` goes high for exactly one cycle.
- R8: A reset event causes `core_init_o` to go high for one cycle on the next edge. In state 3 the state itself is unchanged.
- R9: A snoop request moves state 1 to 2 and state 3 to 4. A snoop-done strobe returns 2 to 1 and 4 to 3. In states 2 and 4, `snoop_en_o` is high and `intr_en_o` is low.
- R10: A halt indication in state 0 moves the state to 1. In state 1, any of init, bus-init, interrupt, NMI, SMI or reset events moves it to 0.
- R11: A stop-clock entry that starts from state 1 returns to state 1, not 0, when `stop_req_ni` is released in state 3.
- R12: After reset the state is 0. `grant_o`, `binit_pend_o`, `core_init_o` and `seq_err_o` are low, and both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_req_ni | input | 1 | Stop-clock request, active low |
| sleep_req_ni | input | 1 | Sleep request, active low |
| halt_i | input | 1 | Halt instruction retired |
| snoop_req_i | input | 1 | Snoop request strobe |
| snoop_done_i | input | 1 | Snoop serviced strobe |
| ev_init_i | input | 1 | Init wake event |
| ev_binit_i | input | 1 | Bus-init event |
| ev_intr_i | input | 1 | Maskable interrupt event |
| ev_nmi_i | input | 1 | Non-maskable interrupt event |
| ev_smi_i | input | 1 | System management interrupt event |
| ev_reset_i | input | 1 | Core reset event |
| sga_resp_i | input | 1 | Response phase of the stop-grant acknowledge cycle |
| state_o | output | 3 | Current power state code |
| grant_o | output | 1 | Clock stop granted |
| snoop_en_o | output | 1 | Snoops accepted |
| intr_en_o | output | 1 | Interrupts accepted |
| binit_pend_o | output | 1 | One-cycle report of a held bus-init |
| core_init_o | output | 1 | Core initialise pulse |
| seq_err_o | output | 1 | Sticky pin sequencing violation |

## Verification
The checker watches several properties on every cycle. The enables must be quiet in sleep and in the snoop states. The error flag must stay set once raised. Every illegal release must set it, and a rise of the grant flag must follow a stop request that was held. Sleep release must return to grant, a reset event in grant must leave the state alone, and the held bus-init report must be a single cycle outside the stopped states. Other behaviour can only be shown by the bench's scenarios, which sample the state one edge before and on the expiry edge. These include the exact delay count, the cancelled delay after an early release, the return to halt versus normal, and the legal release one edge after sleep ends.

// File: rtl/pwr_stpclk_pkg.sv
package pwr_stpclk_pkg;

  typedef enum logic [2:0] {
    PS_NORMAL   = 3'd0,
    PS_HALT     = 3'd1,
    PS_HALT_SNP = 3'd2,
    PS_GRANT    = 3'd3,
    PS_GRANT_SNP = 3'd4,
    PS_SLEEP    = 3'd5
  } pstate_e;

  // clock stop granted: grant, grant-snoop, sleep
  function automatic logic is_stopped(pstate_e s);
    return (s == PS_GRANT) || (s == PS_GRANT_SNP) || (s == PS_SLEEP);
  endfunction

  // states where releasing the stop request is legal
  function automatic logic release_ok(pstate_e s);
    return (s == PS_GRANT) || (s == PS_GRANT_SNP);
  endfunction

  function automatic logic can_arm(pstate_e s);
    return (s == PS_NORMAL) || (s == PS_HALT) || (s == PS_HALT_SNP);
  endfunction

endpackage

// File: rtl/pwr_grant_timer.sv
module pwr_grant_timer #(
  parameter int unsigned DELAY = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt_q;
  logic          run_q;

  // count holds the number of edges since the start edge, expiry on the DELAY-th
  assign expire_o = run_q && (cnt_q == CW'(DELAY)) && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (abort_i || expire_o) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i && !run_q) begin
      run_q <= 1'b1;
      cnt_q <= CW'(1);
    end else if (run_q) begin
      cnt_q <= cnt_q + CW'(1);
    end
  end
endmodule

// File: rtl/pwr_seq_guard.sv
module pwr_seq_guard
  import pwr_stpclk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stop_req_ni,
  input  pstate_e state_i,
  output logic    seq_err_o
);
  logic stop_q;
  logic err_q;
  logic bad_release;

  assign bad_release = stop_req_ni && !stop_q && !release_ok(state_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stop_q <= 1'b1;
      err_q  <= 1'b0;
    end else begin
      stop_q <= stop_req_ni;
      if (bad_release) err_q <= 1'b1;
    end
  end

  assign seq_err_o = err_q;
endmodule

// File: rtl/pwr_event_latch.sv
module pwr_event_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stopped_i,
  input  logic exit_i,
  input  logic binit_i,
  input  logic reset_ev_i,
  output logic binit_pend_o,
  output logic core_init_o
);
  logic held_q;
  logic pend_q;
  logic init_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      pend_q <= 1'b0;
      init_q <= 1'b0;
    end else begin
      init_q <= reset_ev_i;
      pend_q <= exit_i && (held_q || (binit_i && stopped_i));
      if (exit_i)                    held_q <= 1'b0;
      else if (binit_i && stopped_i) held_q <= 1'b1;
    end
  end

  assign binit_pend_o = pend_q;
  assign core_init_o  = init_q;
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_stpclk_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stop_req_ni,
  input  logic    sleep_req_ni,
  input  logic    halt_i,
  input  logic    snoop_req_i,
  input  logic    snoop_done_i,
  input  logic    wake_i,
  input  logic    expire_i,
  output pstate_e state_o,
  output pstate_e state_next_o
);
  pstate_e state_q, state_d;
  logic    from_halt_q, from_halt_d;

  always_comb begin
    state_d     = state_q;
    from_halt_d = from_halt_q;
    case (state_q)
      PS_NORMAL: begin
        if (expire_i) begin
          state_d     = PS_GRANT;
          from_halt_d = 1'b0;
        end else if (halt_i) state_d = PS_HALT;
      end
      PS_HALT: begin
        if (expire_i) begin
          state_d     = PS_GRANT;
          from_halt_d = 1'b1;
        end else if (wake_i)      state_d = PS_NORMAL;
        else if (snoop_req_i)     state_d = PS_HALT_SNP;
      end
      PS_HALT_SNP: begin
        if (expire_i) begin
          state_d     = PS_GRANT_SNP;
          from_halt_d = 1'b1;
        end else if (snoop_done_i) state_d = PS_HALT;
      end
      PS_GRANT: begin
        if (stop_req_ni)       state_d = from_halt_q ? PS_HALT : PS_NORMAL;
        else if (!sleep_req_ni) state_d = PS_SLEEP;
        else if (snoop_req_i)  state_d = PS_GRANT_SNP;
      end
      PS_GRANT_SNP: if (snoop_done_i) state_d = PS_GRANT;
      PS_SLEEP:     if (sleep_req_ni) state_d = PS_GRANT;
      default:      state_d = PS_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= PS_NORMAL;
      from_halt_q <= 1'b0;
    end else begin
      state_q     <= state_d;
      from_halt_q <= from_halt_d;
    end
  end

  assign state_o      = state_q;
  assign state_next_o = state_d;
endmodule

// File: rtl/pwr_stpclk_ctrl.sv
module pwr_stpclk_ctrl
  import pwr_stpclk_pkg::*;
#(
  parameter int unsigned GRANT_DELAY = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       stop_req_ni,
  input  logic       sleep_req_ni,
  input  logic       halt_i,
  input  logic       snoop_req_i,
  input  logic       snoop_done_i,
  input  logic       ev_init_i,
  input  logic       ev_binit_i,
  input  logic       ev_intr_i,
  input  logic       ev_nmi_i,
  input  logic       ev_smi_i,
  input  logic       ev_reset_i,
  input  logic       sga_resp_i,
  output logic [2:0] state_o,
  output logic       grant_o,
  output logic       snoop_en_o,
  output logic       intr_en_o,
  output logic       binit_pend_o,
  output logic       core_init_o,
  output logic       seq_err_o
);
  pstate_e state, state_next;
  logic    expire, start, wake, stopped, exit_stop;

  assign wake      = ev_init_i | ev_binit_i | ev_intr_i | ev_nmi_i | ev_smi_i | ev_reset_i;
  assign start     = sga_resp_i && !stop_req_ni && can_arm(state);
  assign stopped   = is_stopped(state);
  assign exit_stop = stopped && !is_stopped(state_next);

  pwr_grant_timer #(.DELAY(GRANT_DELAY)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .abort_i  (stop_req_ni),
    .expire_o (expire)
  );

  pwr_state_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stop_req_ni  (stop_req_ni),
    .sleep_req_ni (sleep_req_ni),
    .halt_i       (halt_i),
    .snoop_req_i  (snoop_req_i),
    .snoop_done_i (snoop_done_i),
    .wake_i       (wake),
    .expire_i     (expire),
    .state_o      (state),
    .state_next_o (state_next)
  );

  pwr_seq_guard u_guard (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stop_req_ni (stop_req_ni),
    .state_i     (state),
    .seq_err_o   (seq_err_o)
  );

  pwr_event_latch u_evt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .stopped_i    (stopped),
    .exit_i       (exit_stop),
    .binit_i      (ev_binit_i),
    .reset_ev_i   (ev_reset_i),
    .binit_pend_o (binit_pend_o),
    .core_init_o  (core_init_o)
  );

  always_comb begin
    snoop_en_o = 1'b1;
    intr_en_o  = 1'b1;
    case (state)
      PS_HALT_SNP, PS_GRANT_SNP: intr_en_o = 1'b0;
      PS_SLEEP: begin
        snoop_en_o = 1'b0;
        intr_en_o  = 1'b0;
      end
      default: ;
    endcase
  end

  assign state_o = state;
  assign grant_o = stopped;
endmodule

// File: rtl/pwr_stpclk_ctrl_chk.sv
module pwr_stpclk_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       stop_req_ni,
  input logic       sleep_req_ni,
  input logic       snoop_req_i,
  input logic       ev_reset_i,
  input logic [2:0] state_o,
  input logic       grant_o,
  input logic       snoop_en_o,
  input logic       intr_en_o,
  input logic       binit_pend_o,
  input logic       core_init_o,
  input logic       seq_err_o
);
  logic armed_q, stop_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q     <= 1'b0;
      stop_prev_q <= 1'b1;
    end else begin
      armed_q     <= 1'b1;
      stop_prev_q <= stop_req_ni;
    end
  end

  p_grant_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && grant_o && !$past(grant_o)) |-> !$past(stop_req_ni));

  p_err_sticky_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_err_o |=> seq_err_o);

  p_sleep_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5 && sleep_req_ni) |=> (state_o == 3'd3));

  p_sleep_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd5) |-> (!snoop_en_o && !intr_en_o && grant_o));

  p_bad_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != 3'd3 && state_o != 3'd4 && stop_req_ni && !stop_prev_q) |=> seq_err_o);

  p_pend_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binit_pend_o |-> !grant_o);

  p_pend_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    binit_pend_o |=> !binit_pend_o);

  p_reset_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && ev_reset_i && !stop_req_ni && sleep_req_ni && !snoop_req_i)
      |=> (state_o == 3'd3 && core_init_o));

  p_snoop_masks_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd2 || state_o == 3'd4) |-> (snoop_en_o && !intr_en_o));
endmodule

bind pwr_stpclk_ctrl pwr_stpclk_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .stop_req_ni  (stop_req_ni),
  .sleep_req_ni (sleep_req_ni),
  .snoop_req_i  (snoop_req_i),
  .ev_reset_i   (ev_reset_i),
  .state_o      (state_o),
  .grant_o      (grant_o),
  .snoop_en_o   (snoop_en_o),
  .intr_en_o    (intr_en_o),
  .binit_pend_o (binit_pend_o),
  .core_init_o  (core_init_o),
  .seq_err_o    (seq_err_o)
);

// File: tb/pwr_stpclk_ctrl_tb.sv
module pwr_stpclk_ctrl_tb;
  localparam int unsigned DLY = 20;
  localparam logic [2:0] S_NRM = 3'd0, S_HLT = 3'd1, S_HSN = 3'd2,
                         S_GNT = 3'd3, S_GSN = 3'd4, S_SLP = 3'd5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic stop_req_ni = 1'b1, sleep_req_ni = 1'b1;
  logic halt_i = 0, snoop_req_i = 0, snoop_done_i = 0;
  logic ev_init_i = 0, ev_binit_i = 0, ev_intr_i = 0, ev_nmi_i = 0, ev_smi_i = 0, ev_reset_i = 0;
  logic sga_resp_i = 0;
  logic [2:0] state_o;
  logic grant_o, snoop_en_o, intr_en_o, binit_pend_o, core_init_o, seq_err_o;

  always #10 clk_i = ~clk_i;

  pwr_stpclk_ctrl #(.GRANT_DELAY(DLY)) u_dut (.*);

  typedef struct {
    int         due;
    logic [2:0] st;
    logic       pend;
    logic       err;
    logic       cinit;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0, n_cmp = 0, n_bad = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic push(int k, logic [2:0] st, logic pend, logic err, logic ci, string tag);
    exp_t e;
    e.due = cyc + k; e.st = st; e.pend = pend; e.err = err; e.cinit = ci; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk_i);
  endtask

  // monitor: compare items due on this edge, a quarter period after it
  initial forever begin
    @(posedge clk_i);
    #5;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        logic eg, es, ei;
        eg = (q[i].st >= S_GNT);
        es = (q[i].st != S_SLP);
        ei = (q[i].st == S_NRM) || (q[i].st == S_HLT) || (q[i].st == S_GNT);
        n_cmp++;
        if (state_o !== q[i].st || grant_o !== eg || snoop_en_o !== es || intr_en_o !== ei ||
            binit_pend_o !== q[i].pend || seq_err_o !== q[i].err || core_init_o !== q[i].cinit) begin
          n_bad++;
          $display("FAIL %s cyc=%0d: st/g/s/i/p/e/c act=%0d/%b/%b/%b/%b/%b/%b exp=%0d/%b/%b/%b/%b/%b/%b",
                   q[i].tag, cyc, state_o, grant_o, snoop_en_o, intr_en_o, binit_pend_o, seq_err_o,
                   core_init_o, q[i].st, eg, es, ei, q[i].pend, q[i].err, q[i].cinit);
        end
        q.delete(i);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    push(1, S_NRM, 0, 0, 0, "R12 reset state");
    tick(2);

    // R10 / R9 halt path and snoops
    halt_i = 1; push(1, S_HLT, 0, 0, 0, "R10 halt"); tick(1); halt_i = 0;
    snoop_req_i = 1; push(1, S_HSN, 0, 0, 0, "R9 halt snoop"); tick(1); snoop_req_i = 0;
    snoop_done_i = 1; push(1, S_HLT, 0, 0, 0, "R9 halt snoop done"); tick(1); snoop_done_i = 0;
    ev_intr_i = 1; push(1, S_NRM, 0, 0, 0, "R10 wake"); tick(1); ev_intr_i = 0;
    tick(1);

    // R4 sleep ignored outside grant
    sleep_req_ni = 0; push(1, S_NRM, 0, 0, 0, "R4 sleep ignored"); tick(1); sleep_req_ni = 1;
    tick(1);

    // R1 entry from normal
    stop_req_ni = 0; tick(3);
    sga_resp_i = 1;
    push(DLY, S_NRM, 0, 0, 0, "R1 before expiry");
    push(DLY + 1, S_GNT, 0, 0, 0, "R1 grant entry");
    tick(1); sga_resp_i = 0; tick(DLY);

    // R8 reset event in grant
    ev_reset_i = 1;
    push(1, S_GNT, 0, 0, 1, "R8 core init stays");
    push(2, S_GNT, 0, 0, 0, "R8 pulse ends");
    tick(1); ev_reset_i = 0;
    // R7 bus-init held
    ev_binit_i = 1; push(1, S_GNT, 0, 0, 0, "R7 binit held"); tick(1); ev_binit_i = 0;
    // R9 grant snoop
    snoop_req_i = 1; push(1, S_GSN, 0, 0, 0, "R9 grant snoop"); tick(1); snoop_req_i = 0;
    snoop_done_i = 1; push(1, S_GNT, 0, 0, 0, "R9 grant snoop done"); tick(1); snoop_done_i = 0;
    // R4 / R5 sleep
    sleep_req_ni = 0; push(1, S_SLP, 0, 0, 0, "R5 sleep quiet"); tick(3);
    sleep_req_ni = 1; push(1, S_GNT, 0, 0, 0, "R4 sleep exit"); tick(1);
    // R3 / R6 legal release one edge later, R7 report
    stop_req_ni = 1;
    push(1, S_NRM, 1, 0, 0, "R3 release to normal, R7 pend");
    push(2, S_NRM, 0, 0, 0, "R6 legal release, R7 single");
    tick(3);

    // R11 entry from halt
    halt_i = 1; tick(1); halt_i = 0;
    stop_req_ni = 0; tick(2);
    sga_resp_i = 1; push(DLY + 1, S_GNT, 0, 0, 0, "R11 grant from halt");
    tick(1); sga_resp_i = 0; tick(DLY);
    stop_req_ni = 1; push(1, S_HLT, 0, 0, 0, "R11 back to halt"); tick(1);
    ev_nmi_i = 1; push(1, S_NRM, 0, 0, 0, "R10 nmi wake"); tick(1); ev_nmi_i = 0;
    tick(1);

    // R2 early release cancels the delay
    stop_req_ni = 0; tick(1);
    sga_resp_i = 1; tick(1); sga_resp_i = 0; tick(4);
    stop_req_ni = 1; push(1, S_NRM, 0, 1, 0, "R2 early release"); tick(1);
    stop_req_ni = 0; push(DLY + 5, S_NRM, 0, 1, 0, "R2 delay cancelled");
    tick(DLY + 6);
    stop_req_ni = 1; tick(2);

    // R6 release together with sleep exit
    rst_ni = 0; tick(2); rst_ni = 1;
    push(1, S_NRM, 0, 0, 0, "R12 reset clears error");
    stop_req_ni = 0; tick(1);
    sga_resp_i = 1; push(DLY + 1, S_GNT, 0, 0, 0, "R1 grant again");
    tick(1); sga_resp_i = 0; tick(DLY);
    sleep_req_ni = 0; push(1, S_SLP, 0, 0, 0, "R4 sleep entry"); tick(2);
    sleep_req_ni = 1; stop_req_ni = 1;
    push(1, S_GNT, 0, 1, 0, "R6 same-edge release");
    push(2, S_NRM, 0, 1, 0, "R6 then normal");
    tick(4);

    n_bad += q.size();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule